// File: doc/BRIEF.md
# Multi-Mode Auxiliary Timer/Counter

This block is a 16-bit auxiliary timer/counter. It counts up or down and has eight operating modes, chosen by a 3-bit mode field:
- a free timer
- an event counter on an external pin
- two gated timers, one opening on a low pin level and one on a high pin level
- a timer that reloads on a pin edge
- a timer that captures on a pin edge
- two quadrature-encoder modes

The control bits come in as plain level inputs, the way a register file upstream would drive them. They are:
- a run bit and a count-down bit
- an enable for the external direction pin
- a select that hands start/stop control to a partner timer's run bit
- an interrupt-disable bit

A prescaled tick paces the timer modes. All asynchronous pins pass through a two-flop synchroniser, and their edges are taken from the synchronised levels. The count wraps in either direction and flags the wrap with a one-cycle pulse. In the encoder modes, two sticky status flags record count edges and direction reversals. Software clears these flags with a write strobe.

Top module: `aux_timer`

## Requirements
- R1: While rst_n is low, cnt_o, cap_o, wrap_o, irq_o, edge_flag_o and dirchg_flag_o are all 0.
- R2: In mode 000 (timer), each cycle with tick_i high and the run condition true steps the count by one, one edge later. The direction is cnt_down_i XOR (synchronised ext_dir_i AND ext_dir_en_i), and 0 means up.
- R3: With remote_sel_i=0, run_i is the run condition. With remote_sel_i=1, partner_run_i is the run condition and run_i has no effect.
- R4: In mode 001 (counter), each rising edge of ext_pin_i steps the count while the run condition holds, three edges after the pin rises. tick_i has no effect in this mode.
- R5: In mode 010 the timer counts ticks only while the synchronised pin is 0. In mode 011 it counts ticks only while the synchronised pin is 1.
- R6: Modes 100 and 101 count ticks like mode 000. In mode 100 a rising pin edge loads rld_val_i into the count, whether or not the timer runs. In mode 101 a rising pin edge copies the count held before that edge into cap_o.
- R7: In modes 110 and 111, the synchronised pair {enc_b_i, enc_a_i} is decoded as follows, provided the run condition holds. Each single-step move along 00→01→11→10→00 counts one up, and each move the opposite way counts one down. A two-step jump is ignored. cnt_down_i and ext_dir_i have no effect in these modes.
- R8: A step from 0xFFFF up to 0 gives a one-cycle wrap_o pulse. So does a step from 0 down to 0xFFFF. Loads and writes give no pulse.
- R9: In mode 110, irq_o pulses when an encoder step reverses the previous step's direction. In mode 111, irq_o pulses on every encoder step. Both of these are suppressed while irq_dis_i=1. In modes 000–101, irq_o follows wrap_o.
- R10: Flag bit 0 (edge_flag_o) is set by every encoder step. Flag bit 1 (dirchg_flag_o) is set by every encoder direction reversal. Both flags hold until flag_wr_i writes flag_wdata_i. A hardware set wins over a written 0 in the same cycle.
- R11: cnt_wr_i loads cnt_wdata_i into the count on the next edge. It takes priority over a reload and over counting.
- R12: With ext_dir_en_i=0, ext_dir_i has no effect on the count direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled count tick |
| mode_i | input | 3 | Operating mode |
| run_i | input | 1 | Local run bit |
| cnt_down_i | input | 1 | Count direction bit, 1 = down |
| ext_dir_en_i | input | 1 | Connects ext_dir_i to the direction logic |
| remote_sel_i | input | 1 | 1 = run condition taken from partner_run_i |
| irq_dis_i | input | 1 | Masks encoder interrupts |
| partner_run_i | input | 1 | Run bit of the partner timer |
| cnt_wr_i | input | 1 | Software count write strobe |
| cnt_wdata_i | input | 16 | Software count write value |
| rld_val_i | input | 16 | Reload value |
| flag_wr_i | input | 1 | Status flag write strobe |
| flag_wdata_i | input | 2 | Flag write data: bit 0 edge, bit 1 direction change |
| ext_pin_i | input | 1 | Count, gate, reload or capture pin (asynchronous) |
| ext_dir_i | input | 1 | External direction pin (asynchronous) |
| enc_a_i | input | 1 | Encoder channel A (asynchronous) |
| enc_b_i | input | 1 | Encoder channel B (asynchronous) |
| cnt_o | output | 16 | Count value |
| cap_o | output | 16 | Captured count |
| wrap_o | output | 1 | Overflow/underflow pulse |
| irq_o | output | 1 | Interrupt request pulse |
| edge_flag_o | output | 1 | Sticky edge flag |
| dirchg_flag_o | output | 1 | Sticky direction-change flag |

## Verification
The results arrive with two different latencies:
- Stimulus on tick_i, the control bits, cnt_wr_i or flag_wr_i shows up in cnt_o, wrap_o, irq_o and the flags on the first rising edge after it is applied.
- Stimulus on ext_pin_i, ext_dir_i or the encoder pair acts three edges later: two synchroniser flops, then the edge-detect register.

The bench model keeps a three-deep history of sampled pin values to match that delay. It updates at each rising edge and is compared with every output at each falling edge. This means every result is checked in the exact cycle it is due. Directed checks with literal expected values are also sampled at falling edges, a known number of edges after their stimulus.

// File: rtl/aux_timer_pkg.sv
package aux_timer_pkg;

  typedef enum logic [2:0] {
    MODE_TIMER    = 3'b000,
    MODE_COUNTER  = 3'b001,
    MODE_GATE_LO  = 3'b010,
    MODE_GATE_HI  = 3'b011,
    MODE_RELOAD   = 3'b100,
    MODE_CAPTURE  = 3'b101,
    MODE_ENC_ROT  = 3'b110,
    MODE_ENC_EDGE = 3'b111
  } tmode_e;

  // bit positions of the synchronised pin vector
  localparam int SIG_PIN = 0;
  localparam int SIG_DIR = 1;
  localparam int SIG_A   = 2;
  localparam int SIG_B   = 3;
  localparam int NUM_SIG = 4;

  // status flag bit positions
  localparam int FLG_EDGE = 0;
  localparam int FLG_DCHG = 1;
  localparam int NUM_FLG  = 2;

  // position of a {b,a} Gray pair along the forward sequence 00,01,11,10
  function automatic logic [1:0] gray_pos(input logic [1:0] ba);
    return {ba[1], ba[1] ^ ba[0]};
  endfunction

endpackage

// File: rtl/aux_timer_sync.sv
module aux_timer_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stage_d[g] = async_i;
      end else begin : g_next
        assign stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/aux_timer_quad.sv
module aux_timer_quad
  import aux_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] cur_ba_i,
  input  logic [1:0] prev_ba_i,
  output logic       step_o,
  output logic       down_o,
  output logic       dirchg_o
);

  logic [1:0] diff;
  logic       last_down_q, last_down_d;

  always_comb begin
    diff     = gray_pos(cur_ba_i) - gray_pos(prev_ba_i);
    step_o   = en_i && (diff == 2'd1 || diff == 2'd3);
    down_o   = (diff == 2'd3);
    dirchg_o = step_o && (down_o != last_down_q);
    last_down_d = step_o ? down_o : last_down_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_down_q <= 1'b0;
    else if (step_o) last_down_q <= last_down_d;
  end

  // R7: a two-position jump never counts
  a_r7_no_jump_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gray_pos(cur_ba_i) == gray_pos(prev_ba_i) + 2'd2) |-> !step_o);

endmodule

// File: rtl/aux_timer_core.sv
module aux_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             sw_wr_i,
  input  logic [CNT_W-1:0] sw_val_i,
  input  logic             rld_i,
  input  logic [CNT_W-1:0] rld_val_i,
  input  logic             cap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             wrap_evt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q;
  logic             cnt_en, wrap_q;

  always_comb begin
    cnt_en     = sw_wr_i || rld_i || step_i;
    cnt_d      = cnt_q;
    wrap_evt_o = 1'b0;
    if (sw_wr_i) begin
      cnt_d = sw_val_i;
    end else if (rld_i) begin
      cnt_d = rld_val_i;
    end else if (step_i) begin
      if (down_i) begin
        cnt_d      = cnt_q - CNT_W'(1);
        wrap_evt_o = (cnt_q == '0);
      end else begin
        cnt_d      = cnt_q + CNT_W'(1);
        wrap_evt_o = (cnt_q == CNT_MAX);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_q <= '0;
    else if (cap_i) cap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_q <= 1'b0;
    else        wrap_q <= wrap_evt_o;
  end

  assign cnt_o  = cnt_q;
  assign cap_o  = cap_q;
  assign wrap_o = wrap_q;

  // R8: a wrap pulse only appears with the count at an end of its range
  a_r8_wrap_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (cnt_q == '0 || cnt_q == CNT_MAX));

  // R11: a software write lands on the next edge
  a_r11_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> (cnt_q == $past(sw_val_i)));

endmodule

// File: rtl/aux_timer_flags.sv
module aux_timer_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wd_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q, flag_d;

  generate
    for (genvar g = 0; g < N; g++) begin : g_flag
      always_comb begin
        flag_d[g] = set_i[g] | (wr_i ? wd_i[g] : flag_q[g]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[g] <= 1'b0;
        else        flag_q[g] <= flag_d[g];
      end

      // R10: hardware set is never lost
      a_r10_hw_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[g] |=> flag_q[g]);

      // R10: flag stays set unless a 0 is written
      a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[g] && !(wr_i && !wd_i[g])) |=> flag_q[g]);
    end
  endgenerate

  assign flag_o = flag_q;

endmodule

// File: rtl/aux_timer.sv
module aux_timer
  import aux_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [2:0]       mode_i,
  input  logic             run_i,
  input  logic             cnt_down_i,
  input  logic             ext_dir_en_i,
  input  logic             remote_sel_i,
  input  logic             irq_dis_i,
  input  logic             partner_run_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [CNT_W-1:0] rld_val_i,
  input  logic             flag_wr_i,
  input  logic [1:0]       flag_wdata_i,
  input  logic             ext_pin_i,
  input  logic             ext_dir_i,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             wrap_o,
  output logic             irq_o,
  output logic             edge_flag_o,
  output logic             dirchg_flag_o
);

  tmode_e               mode;
  logic [NUM_SIG-1:0]   pins_async, pins_s;
  logic [2:0]           edge_cur, edge_prev_q;
  logic                 run_eff, enc_mode, base_down, pin_rise;
  logic                 step, down, q_step, q_down, q_dirchg;
  logic                 rld, cap, wrap_evt, irq_d, irq_q;
  logic [NUM_FLG-1:0]   flag_set, flags;

  assign mode = tmode_e'(mode_i);

  assign pins_async[SIG_PIN] = ext_pin_i;
  assign pins_async[SIG_DIR] = ext_dir_i;
  assign pins_async[SIG_A]   = enc_a_i;
  assign pins_async[SIG_B]   = enc_b_i;

  aux_timer_sync #(.W(NUM_SIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_async),
    .sync_o  (pins_s)
  );

  // edge-detect history for the pin and the encoder pair: {b, a, pin}
  assign edge_cur = {pins_s[SIG_B], pins_s[SIG_A], pins_s[SIG_PIN]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev_q <= '0;
    else        edge_prev_q <= edge_cur;
  end

  always_comb begin
    run_eff   = remote_sel_i ? partner_run_i : run_i;
    enc_mode  = (mode == MODE_ENC_ROT) || (mode == MODE_ENC_EDGE);
    base_down = cnt_down_i ^ (ext_dir_en_i & pins_s[SIG_DIR]);
    pin_rise  = edge_cur[0] & ~edge_prev_q[0];
  end

  aux_timer_quad u_quad (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (run_eff && enc_mode),
    .cur_ba_i  (edge_cur[2:1]),
    .prev_ba_i (edge_prev_q[2:1]),
    .step_o    (q_step),
    .down_o    (q_down),
    .dirchg_o  (q_dirchg)
  );

  always_comb begin
    step = 1'b0;
    down = base_down;
    rld  = 1'b0;
    cap  = 1'b0;
    unique case (mode)
      MODE_TIMER:   step = tick_i && run_eff;
      MODE_COUNTER: step = pin_rise && run_eff;
      MODE_GATE_LO: step = tick_i && run_eff && !pins_s[SIG_PIN];
      MODE_GATE_HI: step = tick_i && run_eff && pins_s[SIG_PIN];
      MODE_RELOAD: begin
        step = tick_i && run_eff;
        rld  = pin_rise;
      end
      MODE_CAPTURE: begin
        step = tick_i && run_eff;
        cap  = pin_rise;
      end
      default: begin
        step = q_step;
        down = q_down;
      end
    endcase
  end

  aux_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .down_i     (down),
    .sw_wr_i    (cnt_wr_i),
    .sw_val_i   (cnt_wdata_i),
    .rld_i      (rld),
    .rld_val_i  (rld_val_i),
    .cap_i      (cap),
    .cnt_o      (cnt_o),
    .cap_o      (cap_o),
    .wrap_evt_o (wrap_evt),
    .wrap_o     (wrap_o)
  );

  assign flag_set[FLG_EDGE] = q_step;
  assign flag_set[FLG_DCHG] = q_dirchg;

  aux_timer_flags #(.N(NUM_FLG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .wr_i   (flag_wr_i),
    .wd_i   (flag_wdata_i),
    .flag_o (flags)
  );

  always_comb begin
    if (enc_mode)
      irq_d = !irq_dis_i && ((mode == MODE_ENC_ROT) ? q_dirchg : q_step);
    else
      irq_d = wrap_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o         = irq_q;
  assign edge_flag_o   = flags[FLG_EDGE];
  assign dirchg_flag_o = flags[FLG_DCHG];

  // R9: masked encoder events raise no request
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_dis_i && mode_i[2:1] == 2'b11) |=> !irq_o);

  // R3: with remote select and partner stopped, a timer holds its count
  a_r3_remote_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_sel_i && !partner_run_i && mode_i == 3'b000 && !cnt_wr_i) |=> $stable(cnt_o));

  // R5: a closed active-low gate holds the count
  a_r5_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b010 && pins_s[SIG_PIN] && !cnt_wr_i) |=> $stable(cnt_o));

  // R8: loads never produce a wrap pulse
  a_r8_no_wrap_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> !wrap_o);

endmodule

// File: tb/aux_timer_tb_top.sv
module aux_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, run, cdown, xen, rsel, idis, prun, cwr, fwr;
  logic [2:0]  mode;
  logic [15:0] cwd, rld;
  logic [1:0]  fwd;
  logic        pin, xdir, ea, eb;
  logic [15:0] cnt, cap;
  logic        wrap, irq, fedge, fdchg;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  aux_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .run_i(run),
    .cnt_down_i(cdown), .ext_dir_en_i(xen), .remote_sel_i(rsel),
    .irq_dis_i(idis), .partner_run_i(prun), .cnt_wr_i(cwr),
    .cnt_wdata_i(cwd), .rld_val_i(rld), .flag_wr_i(fwr),
    .flag_wdata_i(fwd), .ext_pin_i(pin), .ext_dir_i(xdir),
    .enc_a_i(ea), .enc_b_i(eb), .cnt_o(cnt), .cap_o(cap), .wrap_o(wrap),
    .irq_o(irq), .edge_flag_o(fedge), .dirchg_flag_o(fdchg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed { logic b; logic a; logic d; logic p; } smp_t;
  smp_t        hist[$];
  logic [15:0] m_cnt, m_cap;
  bit          m_wrap, m_irq, m_fe, m_fd, m_last, m_live;

  function automatic int gpos(input logic b, input logic a);
    if (!b && !a) return 0;
    if (!b &&  a) return 1;
    if ( b &&  a) return 2;
    return 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    smp_t cur, prv;
    bit   r, rise, st, dn, enc, ev_e, ev_d, ld, wr;
    int   dd;
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_wrap = 0; m_irq = 0;
      m_fe = 0; m_fd = 0; m_last = 0; m_live = 1;
      hist = {smp_t'(0), smp_t'(0), smp_t'(0)};
    end else begin
      cur  = hist[1];
      prv  = hist[0];
      r    = rsel ? prun : run;
      rise = cur.p && !prv.p;
      dn   = cdown ^ (xen & cur.d);
      enc  = (mode >= 3'd6);
      st   = 0;
      ld   = 0;
      case (mode)
        3'd0, 3'd4, 3'd5: st = tick && r;
        3'd1: st = rise && r;
        3'd2: st = tick && r && !cur.p;
        3'd3: st = tick && r && cur.p;
        default: begin
          dd = (gpos(cur.b, cur.a) - gpos(prv.b, prv.a) + 4) % 4;
          if (r && dd == 1) begin st = 1; dn = 0; end
          if (r && dd == 3) begin st = 1; dn = 1; end
        end
      endcase
      if (mode == 3'd4 && rise) ld = 1;
      if (mode == 3'd5 && rise) m_cap = m_cnt;
      ev_e = enc && st;
      ev_d = ev_e && (dn != m_last);
      if (ev_e) m_last = dn;
      m_wrap = 0;
      if (cwr) m_cnt = cwd;
      else if (ld) m_cnt = rld;
      else if (st) begin
        m_wrap = dn ? (m_cnt == 16'h0000) : (m_cnt == 16'hFFFF);
        m_cnt  = dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
      end
      wr   = fwr;
      m_fe = ev_e | (wr ? fwd[0] : m_fe);
      m_fd = ev_d | (wr ? fwd[1] : m_fd);
      if (enc) m_irq = !idis && ((mode == 3'd6) ? ev_d : ev_e);
      else     m_irq = m_wrap;
      hist.push_back(smp_t'({eb, ea, xdir, pin}));
      void'(hist.pop_front());
    end
  end

  function automatic string cnt_req(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (m_live) begin
      chk(cnt == m_cnt, cnt_req(mode), 32'(cnt), 32'(m_cnt));
      chk(cap == m_cap, "R6 capture", 32'(cap), 32'(m_cap));
      chk(wrap == m_wrap, "R8 wrap", 32'(wrap), 32'(m_wrap));
      chk(irq == m_irq, "R9 irq", 32'(irq), 32'(m_irq));
      chk(fedge == m_fe, "R10 edge flag", 32'(fedge), 32'(m_fe));
      chk(fdchg == m_fd, "R10 dirchg flag", 32'(fdchg), 32'(m_fd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enc_step(input logic b, input logic a, input int hold);
    eb = b; ea = a;
    cyc(hold);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_run();
  end

  initial begin : stim
    logic [15:0] base;
    m_live = 0;
    rst_n = 0; tick = 0; run = 0; cdown = 0; xen = 0; rsel = 0; idis = 0;
    prun = 0; cwr = 0; fwr = 0; mode = 3'd0; cwd = 0; rld = 0; fwd = 0;
    pin = 0; xdir = 0; ea = 0; eb = 0;
    cyc(4);
    // R1: reset state
    chk(cnt == 0 && cap == 0, "R1 counts", 32'({cnt, cap}), 0);
    chk({wrap, irq, fedge, fdchg} == 4'b0, "R1 pulses/flags",
        32'({wrap, irq, fedge, fdchg}), 0);
    rst_n = 1;
    cyc(1);

    // R2: timer mode counts ten ticks
    run = 1; tick = 1;
    cyc(10);
    chk(cnt == 16'd10, "R2 ten ticks", 32'(cnt), 10);
    tick = 0;

    // R12: ext_dir disconnected while enable low
    xdir = 1; cyc(4);
    base = cnt; tick = 1; cyc(5); tick = 0;
    chk(cnt == base + 16'd5, "R12 ext_dir ignored", 32'(cnt), 32'(base + 16'd5));
    xen = 1; cyc(1);
    base = cnt; tick = 1; cyc(5); tick = 0;
    chk(cnt == base - 16'd5, "R2 ext_dir reverses", 32'(cnt), 32'(base - 16'd5));
    xen = 0; xdir = 0; cyc(4);

    // R3: remote select
    rsel = 1; prun = 0; run = 1;
    base = cnt; tick = 1; cyc(5); tick = 0;
    chk(cnt == base, "R3 local run ignored", 32'(cnt), 32'(base));
    prun = 1; run = 0;
    tick = 1; cyc(4); tick = 0;
    chk(cnt == base + 16'd4, "R3 partner run", 32'(cnt), 32'(base + 16'd4));
    rsel = 0; run = 1;

    // R11: write wins over a tick
    cwr = 1; cwd = 16'h1234; tick = 1; cyc(1); cwr = 0; tick = 0;
    chk(cnt == 16'h1234, "R11 write priority", 32'(cnt), 32'h1234);

    // R8: wrap up and down
    cwr = 1; cwd = 16'hFFFE; cyc(1); cwr = 0;
    tick = 1; cyc(4); tick = 0;
    cdown = 1; tick = 1; cyc(4); tick = 0; cdown = 0;

    // R4: counter mode, ticks ignored
    mode = 3'd1; tick = 1;
    for (int i = 0; i < 6; i++) begin pin = 1; cyc(3); pin = 0; cyc(3); end
    cyc(4); tick = 0;

    // R5: gated modes
    for (int g = 2; g <= 3; g++) begin
      mode = 3'(g);
      for (int i = 0; i < 40; i++) begin
        tick = 1'($urandom_range(0, 1));
        if (i % 7 == 0) pin = ~pin;
        cyc(1);
      end
    end
    tick = 0; pin = 0; cyc(4);

    // R6: reload and capture
    mode = 3'd4; rld = 16'hABCD; tick = 1;
    cyc(5); pin = 1; cyc(5); pin = 0; cyc(5);
    run = 0; pin = 1; cyc(5); pin = 0; cyc(4); run = 1;
    mode = 3'd5;
    cyc(3); pin = 1; cyc(4); pin = 0; cyc(6); pin = 1; cyc(4); pin = 0; cyc(4);
    tick = 0;

    // R7, R9, R10: encoder modes
    for (int m = 6; m <= 7; m++) begin
      mode = 3'(m);
      for (int k = 0; k < 2; k++) begin
        idis = 1'(k);
        enc_step(0, 1, 3); enc_step(1, 1, 3); enc_step(1, 0, 3); enc_step(0, 0, 3);
        enc_step(1, 0, 3); enc_step(1, 1, 3);
        enc_step(0, 0, 3);                        // jump: ignored
        enc_step(0, 1, 3); enc_step(0, 0, 3);
        cyc(3);
      end
      fwr = 1; fwd = 2'b00; cyc(1); fwr = 0; cyc(2);
    end
    // R10: clear in the same cycle as a hardware set keeps the flag
    idis = 0;
    eb = 0; ea = 1; cyc(2); fwr = 1; fwd = 2'b00; cyc(1); fwr = 0;
    chk(fedge == 1'b1, "R10 set beats clear", 32'(fedge), 1);
    fwr = 1; fwd = 2'b11; cyc(1); fwr = 0;
    chk({fdchg, fedge} == 2'b11, "R10 write sets", 32'({fdchg, fedge}), 3);
    fwr = 1; fwd = 2'b00; cyc(1); fwr = 0; cyc(3);
    run = 0; cyc(1);
    base = cnt; enc_step(1, 1, 4); enc_step(1, 0, 4);
    chk(cnt == base, "R7 no count when stopped", 32'(cnt), 32'(base));
    run = 1;

    // mixed random operation
    for (int i = 0; i < 4000; i++) begin
      if (i % 60 == 0) mode = 3'($urandom_range(0, 7));
      tick  = 1'($urandom_range(0, 1));
      run   = ($urandom_range(0, 9) != 0);
      cdown = 1'($urandom_range(0, 1));
      xen   = 1'($urandom_range(0, 1));
      rsel  = ($urandom_range(0, 7) == 0);
      prun  = 1'($urandom_range(0, 1));
      idis  = ($urandom_range(0, 3) == 0);
      cwr   = ($urandom_range(0, 49) == 0);
      cwd   = ($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'(0 + $urandom_range(0, 3));
      rld   = 16'($urandom);
      fwr   = ($urandom_range(0, 19) == 0);
      fwd   = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) pin  = ~pin;
      if ($urandom_range(0, 7) == 0) xdir = ~xdir;
      if ($urandom_range(0, 2) == 0) begin
        {eb, ea} = ($urandom_range(0, 1) != 0)
          ? ({eb, ea} == 2'b00 ? 2'b01 : {eb, ea} == 2'b01 ? 2'b11 : {eb, ea} == 2'b11 ? 2'b10 : 2'b00)
          : ({eb, ea} == 2'b00 ? 2'b10 : {eb, ea} == 2'b10 ? 2'b11 : {eb, ea} == 2'b11 ? 2'b01 : 2'b00);
      end
      cyc(1);
    end
    cwr = 0; fwr = 0;
    cyc(5);
    finish_run();
  end

endmodule